// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request lines and presents at most one of them to a host processor. Software reaches it through a one-bit address register port: address 0 is the command port and address 1 is the data/mask port. Three 8-bit registers hold the controller state. The request register holds latched requests. The in-service register holds requests that are being serviced. The mask register holds the disabled lines.

A command write with bit 4 set starts a configuration sequence. The data-port writes that follow are taken, in turn, as a vector base, an optional cascade word and an optional mode word. The mode word can select automatic end-of-interrupt. Other command writes either retire a specific in-service line or choose which status register the command port returns.

The host asks for a vector with a one-cycle `ack` pulse. On the next cycle the block drives the vector and a spurious flag, both qualified by `vec_valid`. Priority is fixed, and line 0 is the highest. Lines are edge-sensed unless level sensing is chosen when the controller is configured.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, `int_out` is 0, the data port reads 0xFF (all lines masked) and the command port reads the request register, which is 0x00.
- R2: A command write of 0x11 starts configuration. The next three data writes load the base word, the cascade word and the mode word. At the end the mask reads 0x00, `casc_cfg` equals the cascade word and `int_out` stays 0 until a request arrives.
- R3: A granted vector is the base word with its low 3 bits replaced by the line number. With base 0x20, line n gives 0x20+n. With base 0x28, line n gives 0x28+n.
- R4: Priority is fixed and line 0 is the highest. `int_out` is 1 only when some unmasked request has a lower line number than every set in-service bit.
- R5: On `ack`, the granted request bit moves from the request register to the in-service register. `vec_valid` is 1 in the following cycle.
- R6: A command write of 0x60+n (n = 0..7) clears in-service bit n and no other bit.
- R7: A command write of 0x0A makes command-port reads return the request register. A write of 0x0B makes them return the in-service register. The choice holds until it is changed again, and configuration resets it to the request register.
- R8: Outside configuration, a data write loads the mask and a data read returns it. A mask bit of 1 keeps that line from raising `int_out` and from being granted, although the request bit still latches.
- R9: An `ack` with no eligible request returns base+7 with `vec_spur`=1 and leaves the in-service register unchanged. This also happens when line 7 is masked.
- R10: When mode-word bit 1 is set (automatic end-of-interrupt), a granted request leaves no in-service bit set.
- R11: In edge mode (first word bit 3 = 0), a rising edge latches a request bit, and the bit clears when the line falls. In level mode (bit 3 = 1), the request register follows the line levels.
- R12: When first-word bit 0 is 0, no mode word is expected, and the data write after the cascade word loads the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = command port, 1 = data/mask port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt to host |
| ack | input | 1 | One-cycle acknowledge pulse |
| vec_valid | output | 1 | Vector outputs valid (cycle after `ack`) |
| vec_out | output | 8 | Returned vector |
| vec_spur | output | 1 | Vector is the spurious line-7 vector |
| casc_cfg | output | 8 | Stored cascade word |

## Verification
Several request patterns are driven. A lone request checks basic latching and the vector. Two requests at once separate the fixed priority from arrival order. A lower-priority request raised while a higher line is in service shows that in-service bits block it, and a higher request raised while a lower line is in service shows that it nests. Requests that fall before `ack`, and `ack` with every line masked, separate a spurious grant from a real one. Separate configurations with a different base, level sensing, no mode word and automatic end-of-interrupt show that each configuration bit changes only its own behaviour.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    CFG_IDLE = 2'd0,
    CFG_BASE = 2'd1,
    CFG_CASC = 2'd2,
    CFG_MODE = 2'd3
  } cfg_state_e;

  localparam logic PORT_CMD  = 1'b0;
  localparam logic PORT_DATA = 1'b1;
  localparam logic [2:0] CMD_EOI_TAG = 3'b011;
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int IDX_W = $clog2(N_IRQ),
  parameter int BASE_W = 8 - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              addr,
  input  logic [7:0]        wdata,
  output logic [BASE_W-1:0] base,
  output logic [7:0]        casc,
  output logic              aeoi,
  output logic              level,
  output logic              ready,
  output logic [N_IRQ-1:0]  mask,
  output logic              rsel_isr,
  output logic              init_clr,
  output logic              eoi_vld,
  output logic [IDX_W-1:0]  eoi_idx
);
  cfg_state_e        st_q, st_d;
  logic [1:0]        need_q, need_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic [7:0]        casc_q, casc_d;
  logic              aeoi_q, aeoi_d, level_q, level_d, ready_q, ready_d, rsel_q, rsel_d;
  logic [N_IRQ-1:0]  mask_q, mask_d;

  always_comb begin
    st_d = st_q; need_d = need_q; base_d = base_q; casc_d = casc_q;
    aeoi_d = aeoi_q; level_d = level_q; ready_d = ready_q;
    mask_d = mask_q; rsel_d = rsel_q;
    init_clr = 1'b0;
    eoi_vld = 1'b0;
    eoi_idx = wdata[IDX_W-1:0];
    if (wr && addr == PORT_CMD) begin
      if (wdata[4]) begin
        st_d = CFG_BASE; need_d = wdata[1:0]; level_d = wdata[3];
        mask_d = '0; rsel_d = 1'b0; aeoi_d = 1'b0; ready_d = 1'b0;
        init_clr = 1'b1;
      end else if (wdata[3]) begin
        if (wdata[1]) rsel_d = wdata[0];
      end else if (wdata[7:5] == CMD_EOI_TAG) begin
        eoi_vld = 1'b1;
      end
    end else if (wr && addr == PORT_DATA) begin
      case (st_q)
        CFG_BASE: begin
          base_d = wdata[7:IDX_W];
          if (!need_q[1]) st_d = CFG_CASC;
          else if (need_q[0]) st_d = CFG_MODE;
          else begin st_d = CFG_IDLE; ready_d = 1'b1; end
        end
        CFG_CASC: begin
          casc_d = wdata;
          if (need_q[0]) st_d = CFG_MODE;
          else begin st_d = CFG_IDLE; ready_d = 1'b1; end
        end
        CFG_MODE: begin
          aeoi_d = wdata[1];
          st_d = CFG_IDLE;
          ready_d = 1'b1;
        end
        default: mask_d = wdata[N_IRQ-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CFG_IDLE; need_q <= '0; base_q <= '0; casc_q <= '0;
      aeoi_q <= 1'b0; level_q <= 1'b0; ready_q <= 1'b0;
      mask_q <= '1; rsel_q <= 1'b0;
    end else if (wr) begin
      st_q <= st_d; need_q <= need_d; base_q <= base_d; casc_q <= casc_d;
      aeoi_q <= aeoi_d; level_q <= level_d; ready_q <= ready_d;
      mask_q <= mask_d; rsel_q <= rsel_d;
    end
  end

  assign base = base_q;
  assign casc = casc_q;
  assign aeoi = aeoi_q;
  assign level = level_q;
  assign ready = ready_q;
  assign mask = mask_q;
  assign rsel_isr = rsel_q;
endmodule

// File: rtl/pic_irr.sv
module pic_irr #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             level,
  input  logic [N_IRQ-1:0] ack_clr,
  output logic [N_IRQ-1:0] irr
);
  logic [N_IRQ-1:0] prev_q, irr_q, irr_d, rise;

  always_comb begin
    rise = irq_in & ~prev_q;
    if (level) irr_d = irq_in;
    else       irr_d = ((irr_q & ~ack_clr) | rise) & irq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq_in;
      irr_q  <= irr_d;
    end
  end

  assign irr = irr_q;
endmodule

// File: rtl/pic_resolve.sv
module pic_resolve #(
  parameter int N_IRQ = 8,
  parameter int IDX_W = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0] pend,
  input  logic [N_IRQ-1:0] isr,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  logic blocked;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    blocked = 1'b0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (isr[i]) blocked = 1'b1;
      if (!blocked && !hit && pend[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [N_IRQ-1:0] irq_in,
  output logic             int_out,
  input  logic             ack,
  output logic             vec_valid,
  output logic [7:0]       vec_out,
  output logic             vec_spur,
  output logic [7:0]       casc_cfg
);
  localparam int IDX_W  = $clog2(N_IRQ);
  localparam int BASE_W = 8 - IDX_W;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [BASE_W-1:0] base;
  logic              aeoi_q, level, ready, rsel_isr, init_clr, eoi_vld;
  logic [IDX_W-1:0]  eoi_idx, win_idx;
  logic [N_IRQ-1:0]  mask_q, irr_q, isr_q, isr_d, ack_clr;
  logic              win_hit, grant;
  logic              vv_q, spur_q, spur_d;
  logic [7:0]        vec_q, vec_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  pic_cfg #(.N_IRQ(N_IRQ)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .base(base), .casc(casc_cfg), .aeoi(aeoi_q), .level(level), .ready(ready),
    .mask(mask_q), .rsel_isr(rsel_isr), .init_clr(init_clr),
    .eoi_vld(eoi_vld), .eoi_idx(eoi_idx)
  );

  pic_irr #(.N_IRQ(N_IRQ)) u_irr (
    .clk(clk), .rst_n(rst_sync_n), .irq_in(irq_in), .level(level),
    .ack_clr(ack_clr), .irr(irr_q)
  );

  pic_resolve #(.N_IRQ(N_IRQ)) u_res (
    .pend(irr_q & ~mask_q), .isr(isr_q), .hit(win_hit), .idx(win_idx)
  );

  assign grant   = ack && win_hit;
  assign ack_clr = grant ? (N_IRQ'(1) << win_idx) : '0;

  always_comb begin
    isr_d = isr_q;
    if (init_clr) begin
      isr_d = '0;
    end else begin
      if (eoi_vld) isr_d[eoi_idx] = 1'b0;
      if (grant && !aeoi_q) isr_d = isr_d | ack_clr;
    end
    if (win_hit) begin
      vec_d  = {base, win_idx};
      spur_d = 1'b0;
    end else begin
      vec_d  = {base, {IDX_W{1'b1}}};
      spur_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      isr_q  <= '0;
      vv_q   <= 1'b0;
      vec_q  <= '0;
      spur_q <= 1'b0;
    end else begin
      isr_q <= isr_d;
      vv_q  <= ack;
      if (ack) begin
        vec_q  <= vec_d;
        spur_q <= spur_d;
      end
    end
  end

  assign int_out   = ready && win_hit;
  assign vec_valid = vv_q;
  assign vec_out   = vec_q;
  assign vec_spur  = spur_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr) bus_rdata[N_IRQ-1:0] = mask_q;
    else if (rsel_isr) bus_rdata[N_IRQ-1:0] = isr_q;
    else bus_rdata[N_IRQ-1:0] = irr_q;
  end
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
  parameter int N_IRQ = 8
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             bus_wr,
  input logic             bus_addr,
  input logic [7:0]       bus_wdata,
  input logic             ack,
  input logic             int_out,
  input logic             vec_valid,
  input logic [7:0]       vec_out,
  input logic             vec_spur,
  input logic [N_IRQ-1:0] irr_q,
  input logic [N_IRQ-1:0] mask_q,
  input logic [N_IRQ-1:0] isr_q,
  input logic             aeoi_q
);
  localparam int IDX_W = $clog2(N_IRQ);

  // R4: an asserted interrupt needs an unmasked latched request
  a_r4_int_has_source: assert property (@(posedge clk) disable iff (!rst_sync_n)
    int_out |-> ((irr_q & ~mask_q) != '0));

  // R5: every acknowledge yields a valid vector next cycle
  a_r5_ack_gives_vector: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ack |=> vec_valid);

  // R9: spurious vectors always carry line 7
  a_r9_spur_line7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vec_valid && vec_spur) |-> (&vec_out[IDX_W-1:0]));

  // R6: specific end-of-interrupt clears its bit
  a_r6_eoi_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && !bus_addr && bus_wdata[7:3] == 5'b01100 && !ack)
      |=> !isr_q[$past(bus_wdata[IDX_W-1:0])]);

  // R10: automatic end-of-interrupt leaves in-service untouched by acks
  a_r10_aeoi_isr_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack && aeoi_q && !bus_wr) |=> $stable(isr_q));
endmodule

bind pic_ctrl pic_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ack(ack), .int_out(int_out), .vec_valid(vec_valid),
  .vec_out(vec_out), .vec_spur(vec_spur), .irr_q(irr_q), .mask_q(mask_q),
  .isr_q(isr_q), .aeoi_q(aeoi_q)
);

// File: tb/sim_pic_ctrl.sv
module sim_pic_ctrl;
  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] irq_in = '0;
  logic       int_out;
  logic       ack = 1'b0;
  logic       vec_valid;
  logic [7:0] vec_out;
  logic       vec_spur;
  logic [7:0] casc_cfg;

  int n_chk = 0;
  int n_fail = 0;
  bit started = 1'b0;

  pic_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .int_out(int_out), .ack(ack), .vec_valid(vec_valid), .vec_out(vec_out),
    .vec_spur(vec_spur), .casc_cfg(casc_cfg)
  );

  always #(CLK_PER/2) clk = ~clk;

  // behavioural reference
  logic [7:0] m_irr, m_isr, m_mask, m_base, m_casc, m_prev, m_vec;
  logic       m_aeoi, m_lvl, m_rdy, m_rsel, m_vv, m_sp;
  logic [1:0] m_need;
  int         m_st;

  function automatic int pick(input logic [7:0] pend, input logic [7:0] svc);
    for (int i = 0; i < 8; i++) begin
      if (svc[i]) return -1;
      if (pend[i]) return i;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_mask = 8'hFF; m_base = 0; m_casc = 0; m_prev = 0;
      m_vec = 0; m_aeoi = 0; m_lvl = 0; m_rdy = 0; m_rsel = 0; m_vv = 0; m_sp = 0;
      m_need = 0; m_st = 0; started = 1'b1;
    end else begin
      int c;
      logic [7:0] clr, nirr;
      c = pick(m_irr & ~m_mask, m_isr);
      clr = 0;
      m_vv = ack;
      if (ack) begin
        if (c >= 0) begin
          m_vec = m_base + 8'(c); m_sp = 0; clr[c] = 1'b1;
          if (!m_aeoi) m_isr[c] = 1'b1;
        end else begin
          m_vec = m_base + 8'd7; m_sp = 1;
        end
      end
      nirr = m_lvl ? irq_in : (((m_irr & ~clr) | (irq_in & ~m_prev)) & irq_in);
      if (bus_wr && !bus_addr) begin
        if (bus_wdata[4]) begin
          m_st = 1; m_need = bus_wdata[1:0]; m_lvl = bus_wdata[3]; m_mask = 0;
          m_rsel = 0; m_aeoi = 0; m_rdy = 0; m_isr = 0;
        end else if (bus_wdata[3]) begin
          if (bus_wdata[1]) m_rsel = bus_wdata[0];
        end else if (bus_wdata[7:5] == 3'b011) m_isr[bus_wdata[2:0]] = 1'b0;
      end else if (bus_wr && bus_addr) begin
        if (m_st == 1) begin
          m_base = bus_wdata & 8'hF8;
          m_st = !m_need[1] ? 2 : (m_need[0] ? 3 : 0);
        end else if (m_st == 2) begin
          m_casc = bus_wdata;
          m_st = m_need[0] ? 3 : 0;
        end else if (m_st == 3) begin
          m_aeoi = bus_wdata[1]; m_st = 0;
        end else m_mask = bus_wdata;
        if (m_st == 0) m_rdy = 1;
      end
      m_irr = nirr;
      m_prev = irq_in;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && rst_n) begin
      chk("R4 int_out vs model", {7'd0, int_out}, {7'd0, m_rdy && pick(m_irr & ~m_mask, m_isr) >= 0});
      chk("R5 vec_valid vs model", {7'd0, vec_valid}, {7'd0, m_vv});
      if (m_vv) begin
        chk("R3 vector vs model", vec_out, m_vec);
        chk("R9 spur flag vs model", {7'd0, vec_spur}, {7'd0, m_sp});
      end
      chk("R7 read data vs model", bus_rdata, bus_addr ? m_mask : (m_rsel ? m_isr : m_irr));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PER * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    // R1 reset state
    chk("R1 int_out after reset", {7'd0, int_out}, 8'h00);
    rd(1'b1, r); chk("R1 mask after reset", r, 8'hFF);
    rd(1'b0, r); chk("R1 request reg after reset", r, 8'h00);

    // R2 configuration, edge, base 0x20, cascade 0x04, mode 0x01
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd(1'b1, r); chk("R2 mask cleared", r, 8'h00);
    chk("R2 cascade stored", casc_cfg, 8'h04);
    chk("R2 no interrupt yet", {7'd0, int_out}, 8'h00);

    // R11 edge latch, R7 read request reg
    irq_in = 8'h08; step();
    chk("R11 edge latched int_out", {7'd0, int_out}, 8'h01);
    rd(1'b0, r); chk("R7 request reg read", r, 8'h08);

    // R4 priority, R3 vector, R5 move to in-service
    irq_in = 8'h0A; step();
    do_ack();
    chk("R3 vector line1", vec_out, 8'h21);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); chk("R5 in-service after ack", r, 8'h02);
    chk("R4 lower line blocked", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); chk("R7 selection persists", r, 8'h02);

    // R6 specific EOI
    wr(1'b0, 8'h61);
    chk("R4 unblocked after EOI", {7'd0, int_out}, 8'h01);
    do_ack();
    chk("R3 vector line3", vec_out, 8'h23);
    irq_in = 8'h0B; step();
    chk("R4 higher line nests", {7'd0, int_out}, 8'h01);
    do_ack();
    chk("R3 vector line0", vec_out, 8'h20);
    rd(1'b0, r); chk("R5 nested in-service", r, 8'h09);
    wr(1'b0, 8'h63);
    rd(1'b0, r); chk("R6 only bit3 cleared", r, 8'h01);
    wr(1'b0, 8'h60);
    irq_in = 8'h00; step();

    // R8 mask, R9 spurious while masked
    wr(1'b1, 8'hFF);
    rd(1'b1, r); chk("R8 mask readback", r, 8'hFF);
    irq_in = 8'h10; step();
    chk("R8 masked line silent", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h0A);
    rd(1'b0, r); chk("R8 request still latched", r, 8'h10);
    do_ack();
    chk("R9 spurious vector masked", vec_out, 8'h27);
    chk("R9 spurious flag", {7'd0, vec_spur}, 8'h01);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); chk("R9 in-service untouched", r, 8'h00);
    wr(1'b1, 8'h00);
    chk("R8 unmask raises int", {7'd0, int_out}, 8'h01);
    irq_in = 8'h00; step();
    chk("R11 fall clears request", {7'd0, int_out}, 8'h00);
    do_ack();
    chk("R9 vanished request vector", vec_out, 8'h27);

    // R12 no mode word, R11 level mode, R3 base 0x28
    wr(1'b0, 8'h18); wr(1'b1, 8'h28); wr(1'b1, 8'h04); wr(1'b1, 8'h40);
    rd(1'b1, r); chk("R12 fourth write is mask", r, 8'h40);
    irq_in = 8'h04; step();
    rd(1'b0, r); chk("R11 level follows input", r, 8'h04);
    do_ack();
    chk("R3 vector base 0x28 line2", vec_out, 8'h2A);
    irq_in = 8'h00; step();
    rd(1'b0, r); chk("R11 level drop", r, 8'h00);

    // R10 automatic end-of-interrupt
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h03);
    irq_in = 8'h10; step();
    do_ack();
    chk("R10 vector line4", vec_out, 8'h24);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); chk("R10 in-service stays clear", r, 8'h00);
    irq_in = 8'h00;
    repeat (3) step();
    finish_run();
  end
endmodule